// File: doc/BRIEF.md
# Serial Receive Break and Activity Flags

This block sits next to a 16x-oversampled asynchronous receive shifter and keeps two status flags for it. The first is a break flag, raised when a complete frame arrives in which every data bit and the stop bit sampled low. The second is an activity flag, raised as soon as the start-bit search sees a low sample in its first oversample slot. When a break is recognized, the block also pulses the framing-error and receive-full set lines for the neighbouring status logic. In 9-bit mode it clears the stored ninth data bit.

The block also holds the shared data buffer. A CPU read returns the last received byte, and a CPU write loads the byte to transmit. The CPU reads a status register and a data register over a simple strobe-and-address bus.

The break flag is cleared only by a status read taken while the flag is set, followed directly by a data read. After a break, the flag stays disarmed until the line has been seen high again. This stops a line that is held low from raising the flag over and over.

Top module: `uart_rx_status`

## Requirements
- R1: The cycle after `char_done` is sampled, the block recognizes a break if three conditions hold. The frame must be all low: every `bit_smp` since the last `start_ev` sampled `rx_in` low. The frame must have the expected length: exactly 9 such samples in 8-bit mode, or 10 in 9-bit mode (data bits plus stop bit). The block must be armed. On a break, `brk_o` becomes 1, and `fe_set_o` and `full_set_o` are 1 for that single cycle.
- R2: On a break, `r8_o` is cleared. On any other completed frame with `nine_bit`=1, `r8_o` takes `rx_bit8`. With `nine_bit`=0, `r8_o` holds its value.
- R3: `brk_o` is cleared only by a data-register read that directly follows a status-register read made while `brk_o` was 1. A data read without that preceding status read leaves `brk_o` at 1.
- R4: The clear sequence is cancelled by any other access between the status read and the data read. This includes a write, a data write, or a read of an unmapped address.
- R5: After a break is recognized, no further break is recognized until the line has been sampled at 1 on an `os_tick`.
- R6: `rip_o` becomes 1 the cycle after `os_tick` and `rt1_slot` are both high while `rx_in` is 0.
- R7: `rip_o` becomes 0 the cycle after `false_start_ev` or `idle_ev`. A clear takes priority over a set in the same cycle.
- R8: A read of the data address (1) returns the byte captured from `rx_byte` at the last `char_done`. A write to the data address sets `tx_byte`. Reset changes neither stored byte.
- R9: A read of the status address (0) returns `brk_o` in bit 1, `rip_o` in bit 0, and zeros in bits 7..2. A read of any other address returns 0.
- R10: Reset clears `brk_o`, `rip_o`, `r8_o`, the pulse outputs and the pending clear sequence, and leaves the block armed for a break.
- R11: A frame with any high sample, or with the wrong number of samples for the mode, does not set `brk_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_in | input | 1 | Synchronized receive line |
| os_tick | input | 1 | Oversample clock enable |
| rt1_slot | input | 1 | First oversample slot of the start-bit search |
| start_ev | input | 1 | Receiver accepted a start bit |
| false_start_ev | input | 1 | Receiver rejected a start bit |
| idle_ev | input | 1 | Receiver saw an idle character |
| bit_smp | input | 1 | Data or stop bit sample point |
| char_done | input | 1 | Frame complete at the stop-bit sample |
| nine_bit | input | 1 | 9-bit character mode |
| rx_byte | input | 8 | Received data byte |
| rx_bit8 | input | 1 | Received ninth bit |
| bus_rd | input | 1 | CPU read strobe |
| bus_wr | input | 1 | CPU write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | CPU write data |
| bus_rdata | output | 8 | CPU read data |
| tx_byte | output | 8 | Byte loaded for transmit |
| brk_o | output | 1 | Break flag |
| rip_o | output | 1 | Reception-in-progress flag |
| r8_o | output | 1 | Stored ninth data bit |
| fe_set_o | output | 1 | Framing-error set pulse |
| full_set_o | output | 1 | Receive-full set pulse |

## Verification
The hardest state to reach is a second break that arrives while the line has never gone high. Reaching it takes a break, a correct status-then-data clear, and then a further all-low frame with no high sample between them. Random frames seldom line up that way.

The stimulus builds this case directly. It then adds one high line sample and sends the same frame again, which must now set the flag. Random phases then mix all-low frames, off-by-one frame lengths and bus accesses that fall between the status and data reads, so that the clear sequence is both completed and cancelled many times.

// File: rtl/uart_rx_status.sv
module uart_rx_status #(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 2,
  parameter logic [ADDR_W-1:0] ST_ADDR = 0,
  parameter logic [ADDR_W-1:0] DT_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_in,
  input  logic              os_tick,
  input  logic              rt1_slot,
  input  logic              start_ev,
  input  logic              false_start_ev,
  input  logic              idle_ev,
  input  logic              bit_smp,
  input  logic              char_done,
  input  logic              nine_bit,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              rx_bit8,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] tx_byte,
  output logic              brk_o,
  output logic              rip_o,
  output logic              r8_o,
  output logic              fe_set_o,
  output logic              full_set_o
);
  localparam int LEN8  = DATA_W + 1;
  localparam int LEN9  = DATA_W + 2;
  localparam int CNT_W = $clog2(LEN9 + 2);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0]  smp_cnt;
  logic              all_low, line_armed, clr_armed;
  logic [DATA_W-1:0] rx_buf;

  wire st_rd    = bus_rd && bus_addr == ST_ADDR;
  wire dt_rd    = bus_rd && bus_addr == DT_ADDR;
  wire any_acc  = bus_rd || bus_wr;
  wire [CNT_W-1:0] frame_len = nine_bit ? CNT_W'(LEN9) : CNT_W'(LEN8);
  wire brk_hit  = char_done && all_low && smp_cnt == frame_len && line_armed;
  wire brk_clr  = dt_rd && clr_armed;
  wire rip_set  = os_tick && rt1_slot && !rx_in;
  wire rip_clr  = false_start_ev || idle_ev;

  always_ff @(posedge clk) begin
    if (start_ev) begin
      smp_cnt <= '0;
      all_low <= 1'b1;
    end else if (bit_smp) begin
      if (smp_cnt != CNT_MAX) smp_cnt <= smp_cnt + 1'b1;
      if (rx_in) all_low <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      brk_o      <= 1'b0;
      rip_o      <= 1'b0;
      r8_o       <= 1'b0;
      fe_set_o   <= 1'b0;
      full_set_o <= 1'b0;
      line_armed <= 1'b1;
      clr_armed  <= 1'b0;
    end else begin
      fe_set_o   <= brk_hit;
      full_set_o <= brk_hit;
      if (brk_hit)      brk_o <= 1'b1;
      else if (brk_clr) brk_o <= 1'b0;
      if (brk_hit)                 line_armed <= 1'b0;
      else if (os_tick && rx_in)   line_armed <= 1'b1;
      if (st_rd)        clr_armed <= brk_o;
      else if (any_acc) clr_armed <= 1'b0;
      if (rip_clr)      rip_o <= 1'b0;
      else if (rip_set) rip_o <= 1'b1;
      if (brk_hit)                    r8_o <= 1'b0;
      else if (char_done && nine_bit) r8_o <= rx_bit8;
    end
  end

  always_ff @(posedge clk) begin
    if (char_done) rx_buf <= rx_byte;
    if (bus_wr && bus_addr == DT_ADDR) tx_byte <= bus_wdata;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ST_ADDR)      bus_rdata = {{(DATA_W-2){1'b0}}, brk_o, rip_o};
    else if (bus_addr == DT_ADDR) bus_rdata = rx_buf;
  end

  p_pulse_with_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fe_set_o |-> (brk_o && full_set_o));
  p_rise_pulses_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_o) |-> fe_set_o);
  p_r8_cleared_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fe_set_o |-> !r8_o);
  p_clear_by_data_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(brk_o) |-> $past(dt_rd));
  p_rip_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rip_set && !rip_clr) |=> rip_o);
  p_rip_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rip_clr |=> !rip_o);
  p_status_zero_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ST_ADDR) |-> bus_rdata[DATA_W-1:2] == '0);
endmodule

// File: tb/uart_rx_status_tb.sv
module uart_rx_status_tb_top;
  logic clk = 0, rst_n = 0;
  logic rx_in = 1, os_tick = 0, rt1_slot = 0, start_ev = 0, false_start_ev = 0, idle_ev = 0;
  logic bit_smp = 0, char_done = 0, nine_bit = 0, rx_bit8 = 0, bus_rd = 0, bus_wr = 0;
  logic [7:0] rx_byte = 0, bus_wdata = 0, bus_rdata, tx_byte;
  logic [1:0] bus_addr = 0;
  logic brk_o, rip_o, r8_o, fe_set_o, full_set_o;
  int n_tests = 0, n_fail = 0;
  logic m_brk = 0, m_rip = 0, m_r8 = 0, m_armed = 1, m_clr = 0;
  logic [7:0] m_rx = 0, m_tx = 0;

  always #2 clk = ~clk;

  uart_rx_status dut_i (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk_state(string tag);
    chk({tag, " brk"}, brk_o, m_brk);
    chk({tag, " rip"}, rip_o, m_rip);
    chk({tag, " r8"},  r8_o,  m_r8);
  endtask

  task automatic line_high();
    os_tick = 1; rx_in = 1; tick(); os_tick = 0;
    m_armed = 1;
    chk_state("R5 line high");
  endtask

  task automatic frame(logic nine, int nsmp, logic [10:0] bits, logic [7:0] d, logic b8);
    logic hit, low;
    start_ev = 1; tick(); start_ev = 0;
    low = 1;
    for (int i = 0; i < nsmp; i++) begin
      bit_smp = 1; os_tick = 1; rx_in = bits[i];
      if (bits[i]) begin low = 0; m_armed = 1; end
      tick();
      bit_smp = 0; os_tick = 0;
    end
    hit = low && (nsmp == (nine ? 10 : 9)) && m_armed;
    nine_bit = nine; rx_byte = d; rx_bit8 = b8; char_done = 1;
    tick();
    char_done = 0;
    chk("R1 fe pulse", fe_set_o, hit);
    chk("R1 full pulse", full_set_o, hit);
    m_rx = d;
    if (hit) begin m_brk = 1; m_armed = 0; m_r8 = 0; end
    else if (nine) m_r8 = b8;
    chk_state("R1/R2/R11 frame");
    tick();
    chk("R1 pulse one cycle", fe_set_o, 0);
  endtask

  task automatic brk_frame(logic nine);
    frame(nine, nine ? 10 : 9, 11'h0, 8'h00, 1'b0);
  endtask

  task automatic rd(logic [1:0] a, string tag);
    logic [7:0] e;
    bus_rd = 1; bus_addr = a; #1;
    e = (a == 0) ? {6'b0, m_brk, m_rip} : (a == 1) ? m_rx : 8'h00;
    chk({tag, " R8/R9 rdata"}, bus_rdata, e);
    tick(); bus_rd = 0;
    if (a == 0) m_clr = m_brk;
    else begin
      if (a == 1 && m_clr) m_brk = 0;
      m_clr = 0;
    end
    chk_state({tag, " R3/R4 after read"});
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d; tick(); bus_wr = 0;
    if (a == 1) m_tx = d;
    m_clr = 0;
    chk("R8 tx byte", tx_byte, m_tx);
  endtask

  task automatic rt1(logic lvl);
    rt1_slot = 1; os_tick = 1; rx_in = lvl; tick(); rt1_slot = 0; os_tick = 0;
    if (!lvl) m_rip = 1; else m_armed = 1;
    chk_state("R6 rt1");
  endtask

  task automatic rip_drop(logic which);
    if (which) idle_ev = 1; else false_start_ev = 1;
    tick(); idle_ev = 0; false_start_ev = 0;
    m_rip = 0;
    chk_state("R7 drop");
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd4242);
    repeat (3) tick();
    rst_n = 1; tick();
    chk_state("R10 reset");
    chk("R10 pulse", fe_set_o, 0);

    // R6 / R7
    rt1(1'b1); rt1(1'b0); rip_drop(1'b0); rt1(1'b0); rip_drop(1'b1);
    rt1_slot = 1; os_tick = 1; rx_in = 0; idle_ev = 1; tick();
    rt1_slot = 0; os_tick = 0; idle_ev = 0;
    chk("R7 clear beats set", rip_o, 0);

    // R8 / R9
    wr(2'd1, 8'h5A);
    frame(1'b0, 9, 11'h1A5, 8'hC3, 1'b0);
    rd(2'd1, "R8 data"); rd(2'd2, "R9 unmapped"); rd(2'd0, "R9 status");

    // R2 nine-bit capture, then break clears it (R1)
    frame(1'b1, 10, 11'h3F1, 8'h77, 1'b1);
    chk("R2 r8 set", r8_o, 1);
    brk_frame(1'b1);
    chk("R1 brk set", brk_o, 1);
    chk("R2 r8 cleared", r8_o, 0);

    // R3 data read alone does not clear
    rd(2'd1, "R3 lone data"); chk("R3 still set", brk_o, 1);
    // R4 intervening access cancels
    rd(2'd0, "R4 st"); wr(2'd0, 8'hFF); rd(2'd1, "R4 dt");
    chk("R4 cancelled", brk_o, 1);
    rd(2'd0, "R4 st"); rd(2'd3, "R4 other"); rd(2'd1, "R4 dt");
    chk("R4 cancelled by read", brk_o, 1);
    rd(2'd0, "R3 st"); rd(2'd1, "R3 dt");
    chk("R3 cleared", brk_o, 0);

    // R5 held-low line does not re-trigger
    brk_frame(1'b0);
    chk("R5 no rearm", brk_o, 0);
    line_high();
    brk_frame(1'b0);
    chk("R5 rearmed", brk_o, 1);
    rd(2'd0, "R3 st"); rd(2'd1, "R3 dt");
    line_high();

    // R11 wrong length / high bit
    frame(1'b0, 10, 11'h0, 8'h00, 1'b0);
    chk("R11 long frame", brk_o, 0);
    frame(1'b1, 9, 11'h0, 8'h00, 1'b0);
    chk("R11 short frame", brk_o, 0);
    line_high();
    frame(1'b0, 9, 11'h100, 8'h00, 1'b0);
    chk("R11 high stop", brk_o, 0);

    // random phase
    for (int k = 0; k < 400; k++) begin
      int op;
      op = $urandom % 9;
      case (op)
        0: begin
          logic nine;
          int n;
          logic [10:0] b;
          nine = 1'($urandom % 2);
          n = (nine ? 10 : 9) + (($urandom % 6 == 0) ? 1 : 0);
          b = ($urandom % 2) ? 11'h0 : 11'($urandom);
          frame(nine, n, b, (b == 0) ? 8'h00 : b[7:0], 1'($urandom % 2));
        end
        1: line_high();
        2, 3: rd(2'd0, "rand st");
        4: rd(2'd1, "rand dt");
        5: rd(2'($urandom % 4), "rand any");
        6: wr(2'($urandom % 4), 8'($urandom));
        7: rt1(1'($urandom % 2));
        default: rip_drop(1'($urandom % 2));
      endcase
    end

    // R8 / R10 reset leaves data buffers
    wr(2'd1, 8'hA5);
    frame(1'b0, 9, 11'h13C, 8'h3C, 1'b0);
    rt1(1'b0);
    rst_n = 0; tick(); tick(); rst_n = 1;
    m_brk = 0; m_rip = 0; m_r8 = 0; m_armed = 1; m_clr = 0;
    chk_state("R10 after reset");
    chk("R8 tx kept", tx_byte, 8'hA5);
    rd(2'd1, "R8 rx kept");
    brk_frame(1'b0);
    chk("R10 armed after reset", brk_o, 1);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule